// File: doc/BRIEF.md
# Character Overlay Video Generator

This block draws a text overlay on a television raster. It runs on the dot clock. It takes its horizontal and vertical timing from external sync inputs. Inside a window whose position can be programmed, the block shows a grid of 8 text rows by 20 character cells. Each cell is 11 dots wide and 15 lines high. The block reads one character code per cell from an internal code memory. A built-in table of 16 glyphs turns each code into a dot pattern. The block drives separate red, green and blue outputs, plus a blank key that tells a downstream mixer where to replace the picture with overlay colour.

Colour is set for each text row, not for each character. One selectable row can act as a level bar. Cells to the left of a programmable split column use the row's own colour, and cells at or right of the split use a second colour. A host loads the code memory and the control registers through a single-cycle write port. Control registers are double-buffered and switch over at the vertical sync leading edge. A change made in the middle of a frame therefore never tears the displayed rows.

Top module: `ovl_gen`

## Requirements
- R1: After reset, all outputs are 0 and every code cell holds 0. The defaults are: overlay start line 2, start dot 8, every row colour 3'b111, and bar mode off.
- R2: The dot counter restarts at the first clock edge that samples `hsync_i` low after it was high. The line counter restarts when `vsync_i` is first sampled high, and it then counts `hsync_i` trailing edges. The output for dot d of a line is registered d+1 edges after that restart edge.
- R3: The window covers lines [vstart, vstart+120) and dots [hstart, hstart+220). Cell row = (line-vstart)/15 and glyph line = remainder. Cell column = (dot-hstart)/11 and glyph dot = remainder. Outside the window, all four outputs are 0.
- R4: A write to address `row*20+col` (0 to 159) stores `wr_data_i[3:0]` as that cell's code. The new code shows from the next dot displayed, including within the current frame.
- R5: Glyph x (0 to 10), line y (0 to 14). The dot is lit as follows:
  - code 0: never lit.
  - codes 1 to 11: lit when x < code.
  - code 12: lit when y is 0 or 14.
  - code 13: lit when x is 0 or 10.
  - code 14: lit when x+y is odd.
  - code 15: always lit.
- R6: `blank_o` is 1 only on lit dots inside the window. Lit colour is red = bit 2, green = bit 1, blue = bit 0 of the chosen 3-bit colour. When `blank_o` is 0, red, green and blue are all 0.
- R7: Address 160+r holds the 3-bit colour (`wr_data_i[2:0]`) used by every cell of row r.
- R8: Address 168 sets bar mode: bit 3 is the enable and bits 2:0 are the bar row. Address 169 holds the second colour in bits 2:0. Address 170 holds the split column in bits 4:0. In the bar row, cells with column >= split use the second colour.
- R9: Writes to addresses 160 to 172 take effect from the next `vsync_i` leading edge. Address 171 holds vstart and address 172 holds hstart, each 8 bits.
- R10: Writes to addresses 173 to 255 change nothing visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high, synchronous to clk_i |
| vsync_i | input | 1 | Vertical sync, active high, synchronous to clk_i |
| wr_en_i | input | 1 | Register or code write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| blank_o | output | 1 | Overlay key, high on lit overlay dots |
| red_o | output | 1 | Red overlay colour |
| green_o | output | 1 | Green overlay colour |
| blue_o | output | 1 | Blue overlay colour |

## Verification
Each fault in internal state shows up as a pattern error on the port of the very next dot.
- A dot counter that is off by one shifts every glyph sideways by one dot.
- A line counter that is off by one shifts glyph rows down a line.
- A wrong cell index picks a neighbour's code, which changes the pattern inside that 11-dot cell.

A shadow register copied at the wrong moment shows either as a colour change part-way through the frame or as a missing change in the frame that follows. The bench therefore compares every dot of every line over four frames against a model built from the requirements, so each of these errors shows at the first affected dot.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int ROWS    = 8;
  localparam int COLS    = 20;
  localparam int GLYPH_W = 11;
  localparam int GLYPH_H = 15;
  localparam int CODE_W  = 4;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int POS_W   = 8;
  localparam int CNT_W   = 9;
  localparam int ROW_W   = $clog2(ROWS);
  localparam int COL_W   = $clog2(COLS);
  localparam int GX_W    = $clog2(GLYPH_W);
  localparam int GY_W    = $clog2(GLYPH_H);

  typedef logic [2:0] rgb_t;

  typedef struct packed {
    logic [POS_W-1:0] vstart;
    logic [POS_W-1:0] hstart;
    logic             bar_en;
    logic [ROW_W-1:0] bar_row;
    rgb_t             bar_rgb;
    logic [COL_W-1:0] split;
  } ctl_t;
endpackage

// File: rtl/ovl_timing.sv
module ovl_timing
  import ovl_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic [POS_W-1:0] vstart_i,
  input  logic [POS_W-1:0] hstart_i,
  output logic             frame_start_o,
  output logic [CW-1:0]    h_cnt_o,
  output logic [CW-1:0]    v_cnt_o,
  output logic             in_win_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [GX_W-1:0]  x_o,
  output logic [GY_W-1:0]  y_o
);
  localparam int RW = CW + 1;
  localparam logic [RW-1:0] WIN_W_V = RW'(COLS * GLYPH_W);
  localparam logic [RW-1:0] WIN_H_V = RW'(ROWS * GLYPH_H);
  localparam logic [RW-1:0] GW_V    = RW'(GLYPH_W);
  localparam logic [RW-1:0] GH_V    = RW'(GLYPH_H);

  logic hs_q, vs_q, h_trail;
  logic [RW-1:0] hrel, vrel, cidx, gx, ridx, gy;
  logic in_h, in_v;

  assign h_trail       = hs_q & ~hsync_i;
  assign frame_start_o = vsync_i & ~vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      h_cnt_o <= '0;
      v_cnt_o <= '0;
    end else begin
      hs_q <= hsync_i;
      vs_q <= vsync_i;
      if (h_trail) h_cnt_o <= '0;
      else if (h_cnt_o != '1) h_cnt_o <= h_cnt_o + 1'b1;
      if (frame_start_o) v_cnt_o <= '0;
      else if (h_trail && v_cnt_o != '1) v_cnt_o <= v_cnt_o + 1'b1;
    end
  end

  always_comb begin
    hrel = {1'b0, h_cnt_o} - RW'(hstart_i);
    vrel = {1'b0, v_cnt_o} - RW'(vstart_i);
    in_h = ({1'b0, h_cnt_o} >= RW'(hstart_i)) && (hrel < WIN_W_V);
    in_v = ({1'b0, v_cnt_o} >= RW'(vstart_i)) && (vrel < WIN_H_V);
    cidx = hrel / GW_V;
    gx   = hrel % GW_V;
    ridx = vrel / GH_V;
    gy   = vrel % GH_V;
    in_win_o = in_h && in_v;
    col_o = in_win_o ? cidx[COL_W-1:0] : '0;
    x_o   = in_win_o ? gx[GX_W-1:0]    : '0;
    row_o = in_win_o ? ridx[ROW_W-1:0] : '0;
    y_o   = in_win_o ? gy[GY_W-1:0]    : '0;
  end
endmodule

// File: rtl/ovl_regs.sv
module ovl_regs
  import ovl_pkg::*;
#(
  parameter int NR = ROWS,
  parameter int NC = COLS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    frame_start_i,
  input  logic [ROW_W-1:0]        rd_row_i,
  input  logic [COL_W-1:0]        rd_col_i,
  output logic [CODE_W-1:0]       code_o,
  output ctl_t                    ctl_o,
  output logic [NR-1:0][2:0]      row_rgb_o
);
  localparam int CELLS   = NR * NC;
  localparam int A_ROWC  = CELLS;
  localparam int A_BAR   = A_ROWC + NR;
  localparam int A_BARC  = A_BAR + 1;
  localparam int A_SPLIT = A_BAR + 2;
  localparam int A_VST   = A_BAR + 3;
  localparam int A_HST   = A_BAR + 4;

  logic [CODE_W-1:0] mem [CELLS];
  logic [ADDR_W-1:0] rd_idx;
  ctl_t pend_ctl;
  logic [NR-1:0][2:0] pend_rgb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CELLS; i++) mem[i] <= '0;
    end else if (wr_en_i && wr_addr_i < ADDR_W'(CELLS)) begin
      mem[wr_addr_i] <= wr_data_i[CODE_W-1:0];
    end
  end

  assign rd_idx = ADDR_W'(rd_row_i) * ADDR_W'(NC) + ADDR_W'(rd_col_i);
  assign code_o = mem[rd_idx];

  for (genvar r = 0; r < NR; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_rgb[r]  <= 3'b111;
        row_rgb_o[r] <= 3'b111;
      end else begin
        if (wr_en_i && wr_addr_i == ADDR_W'(A_ROWC + r)) pend_rgb[r] <= wr_data_i[2:0];
        if (frame_start_i) row_rgb_o[r] <= pend_rgb[r];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_ctl <= '{vstart: POS_W'(2), hstart: POS_W'(8), bar_en: 1'b0,
                    bar_row: '0, bar_rgb: '0, split: '0};
      ctl_o    <= '{vstart: POS_W'(2), hstart: POS_W'(8), bar_en: 1'b0,
                    bar_row: '0, bar_rgb: '0, split: '0};
    end else begin
      if (wr_en_i) begin
        unique case (wr_addr_i)
          ADDR_W'(A_BAR): begin
            pend_ctl.bar_en  <= wr_data_i[3];
            pend_ctl.bar_row <= wr_data_i[ROW_W-1:0];
          end
          ADDR_W'(A_BARC):  pend_ctl.bar_rgb <= wr_data_i[2:0];
          ADDR_W'(A_SPLIT): pend_ctl.split   <= wr_data_i[COL_W-1:0];
          ADDR_W'(A_VST):   pend_ctl.vstart  <= wr_data_i[POS_W-1:0];
          ADDR_W'(A_HST):   pend_ctl.hstart  <= wr_data_i[POS_W-1:0];
          default: ;
        endcase
      end
      if (frame_start_i) ctl_o <= pend_ctl;
    end
  end
endmodule

// File: rtl/ovl_glyph.sv
module ovl_glyph
  import ovl_pkg::*;
#(
  parameter int GW = GLYPH_W,
  parameter int GH = GLYPH_H
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [GX_W-1:0]   x_i,
  input  logic [GY_W-1:0]   y_i,
  output logic              dot_o
);
  always_comb begin
    case (code_i)
      CODE_W'(0):  dot_o = 1'b0;
      CODE_W'(12): dot_o = (y_i == '0) || (y_i == GY_W'(GH - 1));
      CODE_W'(13): dot_o = (x_i == '0) || (x_i == GX_W'(GW - 1));
      CODE_W'(14): dot_o = x_i[0] ^ y_i[0];
      CODE_W'(15): dot_o = 1'b1;
      default:     dot_o = int'(x_i) < int'(code_i);  // fill-level glyphs
    endcase
  end
endmodule

// File: rtl/ovl_gen.sv
module ovl_gen
  import ovl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              blank_o,
  output logic              red_o,
  output logic              green_o,
  output logic              blue_o
);
  logic             frame_start, in_win, dot, lit, use_bar;
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [GX_W-1:0]  gx;
  logic [GY_W-1:0]  gy;
  logic [CODE_W-1:0] code;
  ctl_t             act_ctl;
  logic [ROWS-1:0][2:0] row_rgb;
  rgb_t             pix_rgb;

  ovl_timing #(.CW(CNT_W)) u_timing (
    .clk_i, .rst_ni, .hsync_i, .vsync_i,
    .vstart_i(act_ctl.vstart), .hstart_i(act_ctl.hstart),
    .frame_start_o(frame_start), .h_cnt_o(h_cnt), .v_cnt_o(v_cnt),
    .in_win_o(in_win), .row_o(row), .col_o(col), .x_o(gx), .y_o(gy)
  );

  ovl_regs #(.NR(ROWS), .NC(COLS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .frame_start_i(frame_start), .rd_row_i(row), .rd_col_i(col),
    .code_o(code), .ctl_o(act_ctl), .row_rgb_o(row_rgb)
  );

  ovl_glyph #(.GW(GLYPH_W), .GH(GLYPH_H)) u_glyph (
    .code_i(code), .x_i(gx), .y_i(gy), .dot_o(dot)
  );

  always_comb begin
    lit     = in_win & dot;
    use_bar = act_ctl.bar_en && (row == act_ctl.bar_row) && (col >= act_ctl.split);
    pix_rgb = use_bar ? act_ctl.bar_rgb : row_rgb[row];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_o <= 1'b0;
      {red_o, green_o, blue_o} <= 3'b000;
    end else begin
      blank_o <= lit;
      {red_o, green_o, blue_o} <= lit ? pix_rgb : 3'b000;
    end
  end
endmodule

// File: rtl/ovl_gen_chk.sv
module ovl_gen_chk
  import ovl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hsync_i,
  input logic              vsync_i,
  input logic              blank_o,
  input logic              red_o,
  input logic              green_o,
  input logic              blue_o,
  input logic              frame_start,
  input logic              in_win,
  input logic [CODE_W-1:0] code,
  input logic [CNT_W-1:0]  h_cnt,
  input logic [CNT_W-1:0]  v_cnt,
  input ctl_t              act_ctl
);
  AST_RGB_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_o |-> ({red_o, green_o, blue_o} == 3'b000)); // R6
  AST_OUTSIDE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |=> !blank_o); // R3
  AST_SPACE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code == '0) |=> !blank_o); // R5
  AST_H_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_i) |=> (h_cnt == '0)); // R2
  AST_V_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_i) |=> (v_cnt == '0)); // R2
  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> $stable(act_ctl)); // R9
endmodule

bind ovl_gen ovl_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .vsync_i(vsync_i),
  .blank_o(blank_o), .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
  .frame_start(frame_start), .in_win(in_win), .code(code),
  .h_cnt(h_cnt), .v_cnt(v_cnt), .act_ctl(act_ctl)
);

// File: tb/ovl_gen_tb.sv
`timescale 1ns/1ps
module ovl_gen_tb;
  localparam int LINES = 126;
  localparam int DOTS  = 234;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic blank, red, green, blue;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // bench model, pending and active copies
  int bmem [160];
  int p_rgb [8], a_rgb [8];
  int p_vs = 2, p_hs = 8, p_baren = 0, p_barrow = 0, p_c2 = 0, p_split = 0;
  int a_vs = 2, a_hs = 8, a_baren = 0, a_barrow = 0, a_c2 = 0, a_split = 0;

  ovl_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .blank_o(blank), .red_o(red), .green_o(green), .blue_o(blue)
  );

  always #4 clk = ~clk;

  function automatic bit glyph_ref(int c, int x, int y);
    if (c == 0) return 0;
    if (c == 12) return (y == 0 || y == 14);
    if (c == 13) return (x == 0 || x == 10);
    if (c == 14) return ((x + y) % 2) == 1;
    if (c == 15) return 1;
    return x < c;
  endfunction

  function automatic logic [3:0] exp_px(int ln, int d, output string tag);
    int vr, hr, row, col, c, colr;
    bit lit;
    vr = ln - a_vs;
    hr = d - a_hs;
    if (vr < 0 || vr >= 120 || hr < 0 || hr >= 220) begin
      tag = "R3";
      return 4'b0000;
    end
    row = vr / 15;
    col = hr / 11;
    c = bmem[row*20+col];
    lit = glyph_ref(c, hr % 11, vr % 15);
    if (a_baren != 0 && row == a_barrow) begin
      tag = "R8";
      colr = (col >= a_split) ? a_c2 : a_rgb[row];
    end else begin
      tag = "R7";
      colr = a_rgb[row];
    end
    if (c == 0) tag = "R5";
    return lit ? {1'b1, colr[2:0]} : 4'b0000;
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp, string what);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic wr(int a, int dat);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(dat);
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 160) bmem[a] = dat % 16;
    else if (a < 168) p_rgb[a-160] = dat % 8;
    else if (a == 168) begin p_baren = (dat >> 3) & 1; p_barrow = dat % 8; end
    else if (a == 169) p_c2 = dat % 8;
    else if (a == 170) p_split = dat % 32;
    else if (a == 171) p_vs = dat % 256;
    else if (a == 172) p_hs = dat % 256;
  endtask

  task automatic run_line(int ln, string ftag, int mid_line, int mid_a, int mid_d);
    string tag;
    logic [3:0] exp;
    @(negedge clk); hsync = 1'b1;
    if (ln == mid_line) wr(mid_a, mid_d);
    else repeat (2) @(negedge clk);
    @(negedge clk); hsync = 1'b0;
    @(negedge clk);
    for (int d = 0; d < DOTS; d++) begin
      @(negedge clk);
      exp = exp_px(ln, d, tag);
      check($sformatf("R2/%s/%s", tag, ftag), {blank, red, green, blue}, exp,
            $sformatf("line %0d dot %0d", ln, d));
    end
  endtask

  task automatic run_frame(string ftag, int mid_line, int mid_a, int mid_d);
    @(negedge clk); vsync = 1'b1;
    a_vs = p_vs; a_hs = p_hs; a_baren = p_baren; a_barrow = p_barrow;
    a_c2 = p_c2; a_split = p_split;
    for (int r = 0; r < 8; r++) a_rgb[r] = p_rgb[r];
    @(negedge clk);
    @(negedge clk); vsync = 1'b0;
    for (int ln = 1; ln <= LINES; ln++) run_line(ln, ftag, mid_line, mid_a, mid_d);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 160; i++) bmem[i] = 0;
    for (int r = 0; r < 8; r++) begin p_rgb[r] = 7; a_rgb[r] = 7; end
    repeat (3) @(negedge clk);
    check("R1", {blank, red, green, blue}, 4'b0000, "outputs in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", {blank, red, green, blue}, 4'b0000, "outputs after reset");
  endtask

  // defaults for window, colour, bar; mid-frame bar enable deferred
  task automatic t_defaults;
    for (int i = 0; i < 160; i++) wr(i, (i * 5 + 1) % 16);
    for (int r = 1; r < 7; r++) wr(160 + r, r);
    run_frame("R1/R9", 40, 168, 8 | 3);
  endtask

  // bar split, ignored addresses, deferred vstart
  task automatic t_bar;
    wr(169, 5); wr(170, 9);
    wr(200, 255); wr(255, 8'h12); wr(173, 3);
    run_frame("R8/R10", 20, 171, 5);
  endtask

  // window moved, bar on last row with split 0, immediate code write
  task automatic t_move;
    wr(172, 14); wr(168, 8 | 7); wr(170, 0); wr(169, 2);
    run_frame("R4/R9", 60, 144, 15);
  endtask

  // window at origin, split past last column
  task automatic t_edge;
    wr(171, 1); wr(172, 0); wr(168, 8 | 0); wr(170, 20);
    wr(0, 12); wr(19, 13); wr(20, 14); wr(159, 11);
    run_frame("R3/R8", -1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_bar();
    t_move();
    t_edge();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule